// File: doc/BRIEF.md
# Multi-Converter Chip-Select Read Sequencer

This block sits on the host side of a group of 16-bit successive-approximation converters. All of them share one convert strobe, one serial clock and one serial data return wire. Each converter has its own active-low select line. A single start request raises the convert strobe for every converter at once. The sequencer holds all selects high through the worst-case conversion time. It then walks the selects one at a time, shifts in sixteen bits from the selected converter, and hands each finished word downstream on a valid/ready output together with the index of the converter it came from.

The state machine has six states:

- `ST_IDLE`: convert strobe low.
- `ST_CONVERT`: waits `CONV_WAIT` cycles with all selects high.
- `ST_GAP`: waits `GAP_CYC` idle cycles before each select.
- `ST_SELECT`: one cycle with the select low, in which the MSB is captured.
- `ST_SHIFT`: sixteen serial clock pulses.
- `ST_PRESENT`: word offered downstream.

The transitions are:

- start (`ST_IDLE`→`ST_CONVERT`)
- conversion wait over (`ST_CONVERT`→`ST_GAP`)
- gap over (`ST_GAP`→`ST_SELECT`)
- MSB taken (`ST_SELECT`→`ST_SHIFT`)
- sixteenth pulse done (`ST_SHIFT`→`ST_PRESENT`)
- word accepted, more converters left (`ST_PRESENT`→`ST_GAP`)
- last word accepted (`ST_PRESENT`→`ST_IDLE`)

The serial clock half period (`SCK_HALF` system cycles), the conversion wait and the gap are parameters. Each serial clock pulse is high for `SCK_HALF` cycles and low for `SCK_HALF` cycles, and every pulse is preceded by a low phase of the same length. A data bit is sampled at the end of the low phase that follows each falling edge. This sampling point lies well past the converter's hold time.

Top module: `adc_cs_reader`

## Requirements
- R1: `cnv` rises only while every `sel_n` bit is high, and only from idle after `start` is seen high.
- R2: After reset, and whenever idle, `cnv`=0, `sel_n` is all ones, `sck`=0 and `rd_valid`=0. `cnv` stays high from the cycle after an accepted start until the last converter's word is accepted.
- R3: The first select falls exactly `CONV_WAIT`+`GAP_CYC` cycles after `cnv` rises, and all selects stay high until then.
- R4: At most one `sel_n` bit is low in any cycle. Between releasing one select and lowering the next there are at least `GAP_CYC`+1 cycles with all selects high.
- R5: Each select window carries exactly 16 rising edges of `sck`. `sck` is low whenever no select is low, and it is low when a select falls or is released.
- R6: Bit 15 of `rd_data` is the `sdo` level seen while the select is low and before the first `sck` rise. Bit 15-k is the `sdo` level after the k-th falling edge of `sck` (k=1..15).
- R7: The converters are read in ascending index order 0..N_DEV-1, and `rd_dev` carries the index (binary) of the converter that produced `rd_data`. Exactly N_DEV words are delivered per start.
- R8: While `rd_valid`=1 and `rd_ready`=0, `rd_valid`, `rd_data` and `rd_dev` hold steady, all selects stay high and `sck` stays low.
- R9: `start` has no effect while a read sequence is running. No extra conversion begins, and `cnv` falls once the last word is accepted.
- R10: In the cycle after the last word is accepted the block is idle. A `start` held high then raises `cnv` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to convert and read all converters |
| cnv | output | 1 | Shared convert strobe |
| sck | output | 1 | Shared serial clock |
| sel_n | output | N_DEV | Per-converter select, active low |
| sdo | input | 1 | Shared serial data return |
| rd_valid | output | 1 | Result word available |
| rd_data | output | WORD_W | Result word |
| rd_dev | output | IDX_W | Index of the converter that produced the result |
| rd_ready | input | 1 | Downstream accepts the word |

## Verification
The bench models every converter: it latches a word at the `cnv` rise and drives the selected converter's bits on `sdo`, shifting after each `sck` fall. It uses the patterns all-zeros, all-ones, and words with isolated MSB and LSB.

- A sequencer that samples one edge too early or too late delivers shifted words, so the end bits of those patterns expose it.
- Holding `rd_ready` low for several cycles checks that the word does not move and that no select or clock activity leaks out. A design that kept shifting would corrupt the next converter's read.
- Raising `start` in the middle of a read exposes a sequencer that restarts the conversion.
- Holding `start` across the end of a sequence exposes one that loses the first request after returning to idle.
- Cycle counts measure the conversion wait and the gaps between selects. A short wait would read a converter that is still busy.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_GAP,
        ST_SELECT,
        ST_SHIFT,
        ST_PRESENT
    } rd_state_e;

endpackage

// File: rtl/sck_pacer.sv
module sck_pacer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic low_end
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [HW-1:0] cnt_q;
    logic          at_end;

    assign at_end  = (cnt_q == HW'(HALF - 1));
    assign low_end = at_end && !sck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sck   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            sck   <= 1'b0;
        end else if (at_end) begin
            cnt_q <= '0;
            sck   <= !sck;
        end else begin
            cnt_q <= cnt_q + HW'(1);
        end
    end
endmodule

// File: rtl/word_capture.sv
module word_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (en) begin
            word <= {word[W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/adc_cs_reader.sv
module adc_cs_reader
    import adc_rd_pkg::*;
#(
    parameter int N_DEV     = 4,
    parameter int WORD_W    = 16,
    parameter int SCK_HALF  = 2,
    parameter int CONV_WAIT = 40,
    parameter int GAP_CYC   = 3,
    localparam int IDX_W    = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              cnv,
    output logic              sck,
    output logic [N_DEV-1:0]  sel_n,
    input  logic              sdo,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_dev,
    input  logic              rd_ready
);
    localparam int WAIT_W = $clog2(CONV_WAIT + GAP_CYC + 1);
    localparam int EDGE_W = $clog2(WORD_W + 1);
    localparam logic [IDX_W-1:0]  LAST_DEV = IDX_W'(N_DEV - 1);
    localparam logic [EDGE_W-1:0] LAST_LOW = EDGE_W'(WORD_W);

    rd_state_e         state_q, state_d;
    logic [WAIT_W-1:0] wait_q, wait_d;
    logic [EDGE_W-1:0] edge_q, edge_d;
    logic [IDX_W-1:0]  dev_q, dev_d;
    logic              low_end, pace_run, cap_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wait_q  <= '0;
            edge_q  <= '0;
            dev_q   <= '0;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
            edge_q  <= edge_d;
            dev_q   <= dev_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        wait_d  = wait_q;
        edge_d  = edge_q;
        dev_d   = dev_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_CONVERT;
                    wait_d  = '0;
                    dev_d   = '0;
                end
            end
            ST_CONVERT: begin
                if (wait_q == WAIT_W'(CONV_WAIT - 1)) begin
                    state_d = ST_GAP;
                    wait_d  = '0;
                end else begin
                    wait_d = wait_q + WAIT_W'(1);
                end
            end
            ST_GAP: begin
                if (wait_q == WAIT_W'(GAP_CYC - 1)) begin
                    state_d = ST_SELECT;
                    wait_d  = '0;
                end else begin
                    wait_d = wait_q + WAIT_W'(1);
                end
            end
            ST_SELECT: begin
                state_d = ST_SHIFT;
                edge_d  = '0;
            end
            ST_SHIFT: begin
                if (low_end) begin
                    if (edge_q == LAST_LOW) begin
                        state_d = ST_PRESENT;
                    end else begin
                        edge_d = edge_q + EDGE_W'(1);
                    end
                end
            end
            ST_PRESENT: begin
                if (rd_ready) begin
                    if (dev_q == LAST_DEV) begin
                        state_d = ST_IDLE;
                    end else begin
                        dev_d   = dev_q + IDX_W'(1);
                        state_d = ST_GAP;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cnv      = (state_q != ST_IDLE);
        sel_n    = '1;
        if (state_q == ST_SELECT || state_q == ST_SHIFT) begin
            sel_n[dev_q] = 1'b0;
        end
        rd_valid = (state_q == ST_PRESENT);
        rd_dev   = dev_q;
        pace_run = (state_q == ST_SHIFT) && !(low_end && edge_q == LAST_LOW);
        cap_en   = (state_q == ST_SELECT) ||
                   ((state_q == ST_SHIFT) && low_end &&
                    (edge_q != '0) && (edge_q != LAST_LOW));
    end

    sck_pacer #(.HALF(SCK_HALF)) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (pace_run),
        .sck     (sck),
        .low_end (low_end)
    );

    word_capture #(.W(WORD_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cap_en),
        .bit_in (sdo),
        .word   (rd_data)
    );
endmodule

// File: rtl/adc_cs_reader_chk.sv
module adc_cs_reader_chk #(
    parameter int N_DEV  = 4,
    parameter int WORD_W = 16,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnv,
    input logic              sck,
    input logic [N_DEV-1:0]  sel_n,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [WORD_W-1:0] rd_data,
    input logic [IDX_W-1:0]  rd_dev
);
    assert_all_high_at_cnv_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv) |-> (&sel_n));

    assert_cnv_covers_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(&sel_n) |-> cnv);

    assert_single_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~sel_n) <= 1);

    assert_sck_needs_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !(&sel_n));

    assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_dev)));

    assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((&sel_n) && !sck));
endmodule

bind adc_cs_reader adc_cs_reader_chk #(
    .N_DEV  (N_DEV),
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnv      (cnv),
    .sck      (sck),
    .sel_n    (sel_n),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .rd_dev   (rd_dev)
);

// File: tb/adc_cs_reader_bench.sv
module adc_cs_reader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 4;
    localparam int W    = 16;
    localparam int HALF = 2;
    localparam int CW   = 40;
    localparam int GAP  = 3;
    localparam int IW   = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cnv, sck, sdo;
    logic [N-1:0] sel_n;
    logic         rd_valid;
    logic [W-1:0] rd_data;
    logic [IW-1:0] rd_dev;
    logic         rd_ready = 1'b1;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ready_mode = 0;
    int cnv_rises = 0;

    always #(CLK_PERIOD/2) clk = !clk;

    adc_cs_reader #(
        .N_DEV(N), .WORD_W(W), .SCK_HALF(HALF), .CONV_WAIT(CW), .GAP_CYC(GAP)
    ) u_adc_cs_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .cnv(cnv), .sck(sck),
        .sel_n(sel_n), .sdo(sdo), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_dev(rd_dev), .rd_ready(rd_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp_v);
        end
    endtask

    // converter models: word latched at cnv rise, bits shift on sck fall
    logic [W-1:0] next_word [N];
    logic [W-1:0] conv_word [N];
    int           falls [N];
    logic         m_prev_sck = 1'b0;
    logic [W-1:0] exp_q [$];
    int           exp_dev_q [$];

    always @(posedge cnv) begin
        cnv_rises++;
        chk(&sel_n, "R1", "selects at cnv rise", int'(sel_n), (1 << N) - 1);
        for (int d = 0; d < N; d++) begin
            conv_word[d] = next_word[d];
            exp_q.push_back(next_word[d]);
            exp_dev_q.push_back(d);
        end
    end

    always @(negedge clk) begin
        logic drv;
        drv = 1'b0;
        for (int d = 0; d < N; d++) begin
            if (sel_n[d]) begin
                falls[d] = 0;
            end else begin
                if (m_prev_sck && !sck) falls[d] = falls[d] + 1;
                if (falls[d] < W) drv = conv_word[d][W-1-falls[d]];
            end
        end
        sdo = drv;
        m_prev_sck = sck;
    end

    // reference timing model compared on every clock
    bit          exp_busy = 1'b0;
    int          prev_ones = 0;
    logic        prev_sck = 1'b0;
    bit          seen_sel = 1'b0;
    int          hi_cnt = 0;
    int          idle_cnt = 0;
    int          rises = 0;
    bit          stall_prev = 1'b0;
    logic [W-1:0] held_d;
    logic [IW-1:0] held_i;

    always @(negedge clk) begin
        int ones;
        cyc++;
        if (!rst_n) begin
            exp_busy = 1'b0;
            prev_ones = 0;
            prev_sck = 1'b0;
            seen_sel = 1'b0;
            hi_cnt = 0;
            idle_cnt = 0;
            stall_prev = 1'b0;
        end else begin
            ones = $countones(~sel_n);
            chk(cnv == exp_busy, "R2", "cnv level", int'(cnv), int'(exp_busy));
            chk(ones <= 1, "R4", "selects low", ones, 1);
            if (sck) chk(ones == 1, "R5", "sck with no select", ones, 1);
            if (ones == 1 && prev_ones == 0) begin
                chk(!sck, "R5", "sck at select fall", int'(sck), 0);
                if (!seen_sel) chk(hi_cnt == CW + GAP, "R3", "conversion wait", hi_cnt, CW + GAP);
                else chk(idle_cnt >= GAP + 1, "R4", "gap between selects", idle_cnt, GAP + 1);
                seen_sel = 1'b1;
                rises = 0;
                idle_cnt = 0;
            end
            if (ones == 0 && prev_ones == 1) begin
                chk(rises == W, "R5", "sck rises per window", rises, W);
                chk(!sck, "R5", "sck at release", int'(sck), 0);
            end
            if (sck && !prev_sck) rises++;
            if (ones == 0 && cnv) begin
                if (!seen_sel) hi_cnt++;
                else idle_cnt++;
            end
            if (!cnv) begin
                seen_sel = 1'b0;
                hi_cnt = 0;
            end
            if (stall_prev) begin
                chk(rd_valid, "R8", "valid dropped in stall", int'(rd_valid), 1);
                chk(rd_data == held_d && rd_dev == held_i, "R8", "word moved in stall",
                    int'(rd_data), int'(held_d));
            end
            if (rd_valid) chk(ones == 0 && !sck, "R8", "bus active while offering", ones, 0);
            stall_prev = rd_valid && !rd_ready;
            held_d = rd_data;
            held_i = rd_dev;
            if (rd_valid && rd_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected word", int'(rd_data), 0);
                end else begin
                    logic [W-1:0] ew;
                    int ed;
                    ew = exp_q.pop_front();
                    ed = exp_dev_q.pop_front();
                    chk(rd_data == ew, "R6", "word value", int'(rd_data), int'(ew));
                    chk(int'(rd_dev) == ed, "R7", "device index", int'(rd_dev), ed);
                end
            end
            if (!exp_busy && start) exp_busy = 1'b1;
            else if (rd_valid && rd_ready && int'(rd_dev) == N - 1) exp_busy = 1'b0;
            prev_ones = ones;
            prev_sck = sck;
        end
    end

    // downstream ready pattern
    always @(posedge clk) begin
        #1;
        if (ready_mode == 0) rd_ready = 1'b1;
        else rd_ready = ((cyc % 8) == 7);
    end

    task automatic finish_run();
        wait (cnv === 1'b0);
        repeat (3) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R7", "words left undelivered", exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R10 watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int d = 0; d < N; d++) begin
            next_word[d] = '0;
            conv_word[d] = '0;
            falls[d] = 0;
        end
        repeat (4) @(posedge clk);
        #1;
        chk(cnv == 1'b0 && sck == 1'b0, "R2", "reset cnv/sck", int'({cnv, sck}), 0);
        chk(&sel_n, "R2", "reset selects", int'(sel_n), (1 << N) - 1);
        chk(rd_valid == 1'b0, "R2", "reset valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // run 1: edge patterns, ready always high
        next_word[0] = 16'hA5C3; next_word[1] = 16'h0000;
        next_word[2] = 16'hFFFF; next_word[3] = 16'h8001;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        wait (cnv === 1'b1);
        finish_run();

        // run 2: stalls downstream, start raised mid-sequence
        ready_mode = 1;
        next_word[0] = 16'h1234; next_word[1] = 16'h7FFE;
        next_word[2] = 16'h0001; next_word[3] = 16'hC0DE;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        wait (sel_n[1] === 1'b0);
        @(posedge clk); #1 start = 1'b1;
        repeat (20) @(posedge clk);
        #1 start = 1'b0;
        finish_run();
        repeat (50) @(posedge clk);
        #1;
        chk(cnv_rises == 2, "R9", "conversions after busy start", cnv_rises, 2);
        chk(cnv == 1'b0, "R9", "cnv after sequence", int'(cnv), 0);

        // run 3: start held across the end of a sequence
        ready_mode = 0;
        next_word[0] = 16'h8000; next_word[1] = 16'h0101;
        next_word[2] = 16'hFFFE; next_word[3] = 16'h3C3C;
        @(posedge clk); #1 start = 1'b1;
        wait (cnv === 1'b1);
        next_word[0] = 16'h0F0F; next_word[1] = 16'hE001;
        next_word[2] = 16'h5555; next_word[3] = 16'hAAAA;
        wait (cnv === 1'b0);
        @(posedge clk);
        #1;
        chk(cnv == 1'b1, "R10", "restart one clock after idle", int'(cnv), 1);
        start = 1'b0;
        chk(cnv_rises == 4, "R10", "conversion count", cnv_rises, 4);
        finish_run();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule